// File: doc/BRIEF.md
# Sync-Aligned Dual-Clock Line Buffer

This block is a dual-port word store that sits in a video data path between an application clock and the pixel clock. Words enter on the write clock and leave on the pixel clock, so the buffer serves both as a clock-domain bridge and as a fixed delay. No full or empty flags exist. Each side's address counter is instead pulled back to location zero by a line-timing event. On the write side that event is a falling edge of a line-start strobe. On the read side it is a rising edge of the supplied horizontal timing. As a result, the first active pixel of every line occupies location zero.

A small qualifier decides from a set of static configuration inputs whether the buffer runs in video mode. The qualifier's result is synchronized into each clock domain. Outside video mode, writes are dropped and the read output is forced to zero. The supplied vertical, field and horizontal timing bits come out one pixel clock later, level with the data they belong to.

Top module: `line_sync_buffer`

## Requirements
- R1: `video_mode` is 1 exactly when `en_path` and `en_proc` are both 1, `detect_timing` is 0, and the effective mode field equals 2'b00.
- R2: The effective mode field is forced to 2'b00 when `bypass` is 1 and `asi_sel` and `detect_timing` are both 0. In every other case it equals `mode_cfg`.
- R3: In video mode, each rising `wclk` edge with `wr_zero` sampled low stores the 10-bit `wdata` at the write address, and the write address then advances by one.
- R4: At the first `wclk` edge where `wr_zero` is sampled low after being sampled high, the word is stored at address 0.
- R5: While `wr_zero` is sampled high, nothing is stored and the write address holds its value.
- R6: An edge of `pclk` that samples `h_in` high, after `h_in` was sampled low at the previous edge, makes `rdata` show the word at address 0 one `pclk` cycle later. Each following cycle shows the next address in turn.
- R7: `h_out`, `v_out` and `f_out` repeat `h_in`, `v_in` and `f_in` one `pclk` cycle later, in the same cycle as the matching `rdata`.
- R8: Both addresses wrap from DEPTH-1 back to 0, and no overflow or underflow indication is produced.
- R9: Outside video mode (once the change has crossed its two-stage synchronizer), writes are ignored, `rdata` is 0, and the stored contents are kept.
- R10: `blank_in` must stay low while in video mode. It has no effect on the stored data.
- R11: During reset, `rdata`, `h_out`, `v_out` and `f_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_zero | input | 1 | Line-start strobe; falling edge returns write address to 0 |
| wdata | input | 10 | Write word |
| pclk | input | 1 | Pixel (read) clock |
| prst_n | input | 1 | Synchronous active-low reset, read domain |
| h_in | input | 1 | Supplied horizontal timing; rising edge returns read address to 0 |
| v_in | input | 1 | Supplied vertical timing |
| f_in | input | 1 | Supplied field timing |
| blank_in | input | 1 | Blanking request; must be low in video mode |
| en_path | input | 1 | First enable for video mode |
| en_proc | input | 1 | Second enable for video mode |
| mode_cfg | input | 2 | Configured mode field |
| detect_timing | input | 1 | Timing-detect select; blocks video mode when high |
| bypass | input | 1 | Bypass select; forces mode field default |
| asi_sel | input | 1 | Alternate-stream select |
| video_mode | output | 1 | Qualifier result (combinational) |
| rdata | output | 10 | Read word, zero outside video mode |
| h_out | output | 1 | Horizontal timing, delayed to match `rdata` |
| v_out | output | 1 | Vertical timing, delayed to match `rdata` |
| f_out | output | 1 | Field timing, delayed to match `rdata` |

## Verification
The bench builds the buffer with DEPTH set to 64 instead of 2048. This lets a single 70-word line run both address counters past the last location and back to zero, so the wrap-around is checked with only a few hundred clocks. The write clock period is 10 and the pixel clock period is 14. With these values the two clock edges drift against each other, and the bench covers both a line read after it is fully written and a read that trails a write still in progress.

// File: rtl/lsb_pkg.sv
// Shared constants for the sync-aligned line buffer.
package lsb_pkg;
    // Width of one video word on both ports.
    localparam int WORD_W = 10;
    // Mode field value that selects video operation.
    localparam logic [1:0] MODE_VIDEO = 2'b00;
endpackage

// File: rtl/lsb_mode_qual.sv
// Mode qualifier: combines static configuration inputs into one video-mode
// enable. Assumes the inputs are quasi-static (changed only while idle).
module lsb_mode_qual
    import lsb_pkg::*;
(
    input  logic       en_path,
    input  logic       en_proc,
    input  logic [1:0] mode_cfg,
    input  logic       detect_timing,
    input  logic       bypass,
    input  logic       asi_sel,
    output logic       video_ok
);
    logic [1:0] eff_mode;

    // Resolve the effective mode field, applying the bypass default.
    always_comb begin
        if (bypass && !asi_sel && !detect_timing) begin
            eff_mode = MODE_VIDEO;
        end else begin
            eff_mode = mode_cfg;
        end
    end

    // Video mode needs both enables, no timing detect and the video field.
    always_comb begin
        video_ok = en_path && en_proc && !detect_timing && (eff_mode == MODE_VIDEO);
    end
endmodule

// File: rtl/lsb_sync.sv
// Level synchronizer: carries a slow level into a clock domain through a
// chain of STAGES flops. Assumes STAGES >= 2 and a level held for several
// destination cycles.
module lsb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lsb_dpram.sv
// Simple dual-port word store: one write port on wclk, one registered read
// port on pclk. Assumes the two ports never touch the same address on
// coincident edges (the line timing keeps the reader behind the writer).
module lsb_dpram #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 2048,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pclk,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per enabled write-clock edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Fetch the addressed word on every pixel-clock edge.
    always_ff @(posedge pclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lsb_wr_ctrl.sv
// Write address control: detects the falling edge of the line-start strobe
// in the write domain, steers that word to address 0 and counts upward with
// wrap. Assumes mode_w is already synchronized to wclk.
module lsb_wr_ctrl #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          mode_w,
    input  logic          wr_zero,
    output logic          we,
    output logic [AW-1:0] waddr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ONE  = (DEPTH > 1) ? AW'(1) : '0;

    logic          wz_q;
    logic          fall;
    logic [AW-1:0] wr_ptr;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wz_q <= 1'b0;
        end else begin
            wz_q <= wr_zero;
        end
    end

    // Realign on the falling edge; otherwise use the running address.
    always_comb begin
        fall  = wz_q && !wr_zero;
        waddr = fall ? '0 : wr_ptr;
        we    = mode_w && !wr_zero;
    end

    // Advance the address after each stored word, wrapping at the top.
    always_ff @(posedge wclk) begin
        if (!wrst_n || !mode_w) begin
            wr_ptr <= '0;
        end else if (we) begin
            wr_ptr <= (waddr == LAST) ? '0 : waddr + ONE;
        end
    end

    // R4: after a falling edge the next free address is one past zero.
    a_r4_fall_realign: assert property (@(posedge wclk) disable iff (!wrst_n)
        (mode_w && wz_q && !wr_zero) |=> (wr_ptr == ONE));
    // R5: while the strobe is high the address does not move.
    a_r5_hold_ptr: assert property (@(posedge wclk) disable iff (!wrst_n)
        (mode_w && wr_zero) |=> $stable(wr_ptr));
    // R8: a write at the last address is followed by address zero.
    a_r8_wr_wrap: assert property (@(posedge wclk) disable iff (!wrst_n)
        (we && !fall && wr_ptr == LAST) |=> (wr_ptr == '0));
endmodule

// File: rtl/lsb_rd_ctrl.sv
// Read address control: realigns to address 0 on a rising edge of the
// supplied horizontal timing and otherwise walks sequentially with wrap.
// Assumes mode_p is already synchronized to pclk.
module lsb_rd_ctrl #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          pclk,
    input  logic          prst_n,
    input  logic          mode_p,
    input  logic          h_in,
    output logic [AW-1:0] raddr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ONE  = (DEPTH > 1) ? AW'(1) : '0;

    logic          h_q;
    logic          h_rise;
    logic [AW-1:0] rd_ptr;

    // Remember the previous horizontal level for edge detection.
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            h_q <= 1'b0;
        end else begin
            h_q <= h_in;
        end
    end

    // Select address zero on a horizontal rising edge.
    always_comb begin
        h_rise = h_in && !h_q;
        raddr  = h_rise ? '0 : rd_ptr;
    end

    // Step to the following address each pixel clock, wrapping at the top.
    always_ff @(posedge pclk) begin
        if (!prst_n || !mode_p) begin
            rd_ptr <= '0;
        end else begin
            rd_ptr <= (raddr == LAST) ? '0 : raddr + ONE;
        end
    end

    // R6: a horizontal rising edge leaves the read address one past zero.
    a_r6_h_realign: assert property (@(posedge pclk) disable iff (!prst_n)
        (mode_p && h_in && !h_q) |=> (rd_ptr == ONE));
    // R8: reading the last address is followed by address zero.
    a_r8_rd_wrap: assert property (@(posedge pclk) disable iff (!prst_n)
        (mode_p && !(h_in && !h_q) && rd_ptr == LAST) |=> (rd_ptr == '0));
endmodule

// File: rtl/line_sync_buffer.sv
// Sync-aligned dual-clock line buffer top: qualifies video mode, carries it
// into both clock domains, and joins the write control, read control and
// word store. Outputs are zero outside video mode. Assumes configuration
// inputs change only while no line is in flight.
module line_sync_buffer
    import lsb_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int DEPTH  = 2048,
    parameter int SYNC_N = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_zero,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pclk,
    input  logic              prst_n,
    input  logic              h_in,
    input  logic              v_in,
    input  logic              f_in,
    input  logic              blank_in,
    input  logic              en_path,
    input  logic              en_proc,
    input  logic [1:0]        mode_cfg,
    input  logic              detect_timing,
    input  logic              bypass,
    input  logic              asi_sel,
    output logic              video_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              h_out,
    output logic              v_out,
    output logic              f_out
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              mode_w;
    logic              mode_p;
    logic              mode_q;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [DATA_W-1:0] ram_q;

    lsb_mode_qual u_qual (
        .en_path       (en_path),
        .en_proc       (en_proc),
        .mode_cfg      (mode_cfg),
        .detect_timing (detect_timing),
        .bypass        (bypass),
        .asi_sel       (asi_sel),
        .video_ok      (video_mode)
    );

    lsb_sync #(.STAGES(SYNC_N)) u_sync_w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (video_mode),
        .q     (mode_w)
    );

    lsb_sync #(.STAGES(SYNC_N)) u_sync_p (
        .clk   (pclk),
        .rst_n (prst_n),
        .d     (video_mode),
        .q     (mode_p)
    );

    lsb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .wclk    (wclk),
        .wrst_n  (wrst_n),
        .mode_w  (mode_w),
        .wr_zero (wr_zero),
        .we      (we),
        .waddr   (waddr)
    );

    lsb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .pclk   (pclk),
        .prst_n (prst_n),
        .mode_p (mode_p),
        .h_in   (h_in),
        .raddr  (raddr)
    );

    lsb_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .pclk  (pclk),
        .raddr (raddr),
        .rdata (ram_q)
    );

    // Delay the mode and timing bits by one cycle to line up with the store.
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            mode_q <= 1'b0;
            h_out  <= 1'b0;
            v_out  <= 1'b0;
            f_out  <= 1'b0;
        end else begin
            mode_q <= mode_p;
            h_out  <= h_in;
            v_out  <= v_in;
            f_out  <= f_in;
        end
    end

    // Gate the fetched word to zero outside video mode.
    always_comb begin
        rdata = mode_q ? ram_q : '0;
    end

    // R7: timing bits come out one pixel clock after they go in.
    a_r7_timing_delay: assert property (@(posedge pclk) disable iff (!prst_n)
        1'b1 |=> (h_out == $past(h_in) && v_out == $past(v_in) && f_out == $past(f_in)));
    // R9: outside video mode the read word is zero on the next cycle.
    a_r9_zero_when_off: assert property (@(posedge pclk) disable iff (!prst_n)
        !mode_p |=> (rdata == '0));
    // R10: blanking is a protocol violation in video mode.
    a_r10_no_blank: assert property (@(posedge pclk) disable iff (!prst_n)
        mode_p |-> !blank_in);
endmodule

// File: tb/line_sync_buffer_tb.sv
module line_sync_buffer_tb;
    localparam int WCLK_PERIOD = 10;
    localparam int PCLK_PERIOD = 14;
    localparam int DEPTH       = 64;
    localparam int DW          = 10;

    logic          wclk = 1'b0;
    logic          pclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_zero = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic          h_in = 1'b0, v_in = 1'b0, f_in = 1'b0, blank_in = 1'b0;
    logic          en_path = 1'b1, en_proc = 1'b1;
    logic [1:0]    mode_cfg = 2'b00;
    logic          detect_timing = 1'b0, bypass = 1'b0, asi_sel = 1'b0;
    logic          video_mode;
    logic [DW-1:0] rdata;
    logic          h_out, v_out, f_out;

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(PCLK_PERIOD/2) pclk = ~pclk;

    line_sync_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .wclk(wclk), .wrst_n(rst_n), .wr_zero(wr_zero), .wdata(wdata),
        .pclk(pclk), .prst_n(rst_n), .h_in(h_in), .v_in(v_in), .f_in(f_in),
        .blank_in(blank_in), .en_path(en_path), .en_proc(en_proc),
        .mode_cfg(mode_cfg), .detect_timing(detect_timing), .bypass(bypass),
        .asi_sel(asi_sel), .video_mode(video_mode), .rdata(rdata),
        .h_out(h_out), .v_out(v_out), .f_out(f_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    bit cmp_en = 0;
    bit model_on = 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: word array with valid marks and two counters.
    logic [DW-1:0] mem_m [DEPTH];
    bit            vld   [DEPTH];
    int            wptr = 0;
    bit            wzp  = 0;
    int            rptr = 0;
    bit            hp   = 0;
    logic [DW-1:0] exp_d = '0;
    bit            exp_ok = 0, exp_on = 0;
    logic [2:0]    exp_t = '0;

    always @(posedge wclk) begin
        int a;
        if (!rst_n) begin
            wptr = 0; wzp = 0;
        end else begin
            if (model_on && !wr_zero) begin
                a = wzp ? 0 : wptr;
                mem_m[a] = wdata; vld[a] = 1;
                wptr = (a + 1) % DEPTH;
            end else if (!model_on) begin
                wptr = 0;
            end
            wzp = wr_zero;
        end
    end

    always @(posedge pclk) begin
        int a;
        if (!rst_n) begin
            rptr = 0; hp = 0; exp_on = 0; exp_ok = 0; exp_t = '0;
        end else begin
            a = (h_in && !hp) ? 0 : rptr;
            exp_ok = vld[a];
            exp_d  = mem_m[a];
            exp_on = model_on;
            rptr   = model_on ? (a + 1) % DEPTH : 0;
            hp     = h_in;
            exp_t  = {h_in, v_in, f_in};
        end
    end

    // Compare every pixel clock, away from the active edge.
    always @(negedge pclk) begin
        if (cmp_en && !done) begin
            chk("R7", {29'd0, h_out, v_out, f_out}, {29'd0, exp_t});
            if (!exp_on) chk("R9", 32'(rdata), 32'd0);
            else if (exp_ok) chk("R3 R6", 32'(rdata), 32'(exp_d));
        end
    end

    function automatic logic [DW-1:0] pat(input int seed, input int i);
        return DW'((seed * 97 + i * 13 + (i >> 3)) & 10'h3FF);
    endfunction

    task automatic write_line(input int n, input int seed);
        @(negedge wclk) wr_zero = 1'b1;
        @(negedge wclk);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk) wr_zero = 1'b0; wdata = pat(seed, i);
        end
        @(negedge wclk) wr_zero = 1'b1; wdata = '1;
    endtask

    task automatic read_line(input int n);
        @(negedge pclk) h_in = 1'b1; v_in = ~v_in;
        @(negedge pclk) cmp_en = 1; h_in = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge pclk) f_in = i[1]; v_in = i[3];
        end
    endtask

    task automatic set_mode(input bit on);
        cmp_en = 0;
        @(negedge wclk) en_path = on; model_on = on;
        repeat (8) @(negedge pclk);
    endtask

    initial begin
        // R1, R2: qualifier truth cases, checked while held in reset.
        #1 chk("R1", 32'(video_mode), 32'd1);
        en_path = 0; #1 chk("R1", 32'(video_mode), 32'd0);
        en_path = 1; en_proc = 0; #1 chk("R1", 32'(video_mode), 32'd0);
        en_proc = 1; mode_cfg = 2'b01; #1 chk("R1", 32'(video_mode), 32'd0);
        bypass = 1; #1 chk("R2", 32'(video_mode), 32'd1);
        asi_sel = 1; mode_cfg = 2'b10; #1 chk("R2", 32'(video_mode), 32'd0);
        asi_sel = 0; mode_cfg = 2'b11; detect_timing = 1; #1 chk("R2", 32'(video_mode), 32'd0);
        bypass = 0; mode_cfg = 2'b00; #1 chk("R1", 32'(video_mode), 32'd0);
        detect_timing = 0; #1 chk("R1", 32'(video_mode), 32'd1);

        // R11: outputs stay zero in reset even with timing inputs high.
        h_in = 1; v_in = 1; f_in = 1;
        repeat (4) @(negedge pclk);
        chk("R11", {29'd0, h_out, v_out, f_out}, 32'd0);
        chk("R11", 32'(rdata), 32'd0);
        h_in = 0; v_in = 0; f_in = 0;
        @(negedge wclk) rst_n = 1'b1;
        repeat (10) @(negedge pclk);

        // R3 R4 R6: write a full line, then read it from location zero.
        write_line(40, 1);
        read_line(40);
        // R4: a shorter line realigns to zero; older tail words stay intact.
        write_line(25, 2);
        read_line(45);
        // R8: a line longer than DEPTH wraps both counters.
        write_line(70, 3);
        read_line(70);
        // R5: data driven with the strobe high is not stored.
        for (int i = 0; i < 20; i++) begin
            @(negedge wclk) wdata = pat(9, i);
        end
        read_line(30);
        // Fixed delay: the read trails a write still in progress.
        fork
            write_line(50, 4);
            begin repeat (25) @(negedge wclk); read_line(50); end
        join

        // R9 R10: leave video mode; writes dropped, output zero, blank harmless.
        set_mode(0);
        cmp_en = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge wclk) wr_zero = i[3]; wdata = pat(7, i); blank_in = i[2];
        end
        @(negedge wclk) wr_zero = 1'b1; blank_in = 1'b0;
        repeat (4) @(negedge pclk);
        set_mode(1);
        // R9: stored contents kept across the off period.
        read_line(50);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge wclk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule